// File: doc/BRIEF.md
# Sysex Shift Command Decoder

This block sits between a byte-wide command stream and a shift-register engine. It reads framed system-exclusive messages that address the shift feature. It decodes the command byte into a command code and a shift type, and collects the per-message fields. Configuration messages set a stored profile: data pin, clock pin, bit order and an optional latch or load pin. Shift-out messages name a data pin and stream their payload bytes to the engine over a valid/ready handshake. Shift-in messages produce a single-cycle request that carries a data pin and a byte count.

In the other direction, the block wraps bytes captured by the engine into a reply message on an outgoing byte stream. A reply begins with a header, then the data pin so the host can pair it with its request, then the data, then an end marker. Messages for other features, malformed frames and aborted frames leave every output and all stored state unchanged.

Top module: `shift_sysex_decoder`

## Requirements
- R1: A message is decoded only when a 0xF0 byte is followed directly by the feature byte 0x75. A frame with any other feature byte is skipped up to its 0xF7. Data bytes outside a frame are ignored.
- R2: The third byte of a frame is the command byte. Bits [2:0] hold the command: 1 = shift-out, 2 = shift-in, 4 = config. Bits [5:3] hold the shift type. Any other command value makes the frame skipped.
- R3: A config frame carries data pin, clock pin, bit order and an optional latch pin, in that order. Bit 0 of the bit-order byte set means MSB first. The profile is stored when 0xF7 is accepted, and only if at least the first three fields arrived. `cfg_latch_valid` is 1 exactly when the fourth field arrived. Bytes after the fourth field are ignored.
- R4: Shift types are 0 plain out, 1 plain in, 2 latch-low-then-out, 3 latch-low/out/latch-high, 4 out-then-latch-high, and 5 pulse-load-then-in. When no latch pin is valid, types 2, 3 and 4 are reported as 0 and type 5 as 1. Other values pass through unchanged.
- R5: In a shift-out frame, every data byte after the data pin is presented on `pay_data`, in order, with that pin and the effective type. It is held stable until `pay_ready` is seen with `pay_valid`.
- R6: A shift-in frame that carries a data pin raises `rd_req` for exactly one cycle after its 0xF7 is accepted. The request carries the pin and the count. A missing or zero count is reported as 1, and bytes after the count are ignored.
- R7: Any byte with bit 7 set, other than 0xF7, aborts the current frame without storing or requesting anything. A 0xF0 also starts a fresh frame.
- R8: While a payload byte is waiting for the engine, `in_ready` is low and no input byte is consumed.
- R9: A reply is sent as 0xF0, 0x75, 0x03, the data pin, each data byte, and then 0xF7. Every byte is held until `tx_ready` is seen.
- R10: After reset, no profile is stored, the latch pin is invalid, `pay_valid`, `rd_req` and `tx_valid` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Incoming byte valid |
| in_data | input | 8 | Incoming byte |
| in_ready | output | 1 | Incoming byte accepted when high |
| cfg_valid | output | 1 | A profile has been stored |
| cfg_data_pin | output | 7 | Stored data pin |
| cfg_clk_pin | output | 7 | Stored clock pin |
| cfg_msb_first | output | 1 | Stored bit order, 1 = MSB first |
| cfg_latch_pin | output | 7 | Stored latch/load pin |
| cfg_latch_valid | output | 1 | Latch/load pin present |
| cfg_type | output | 3 | Effective shift type of the stored profile |
| pay_valid | output | 1 | Payload byte offered to the engine |
| pay_ready | input | 1 | Engine takes the payload byte |
| pay_data | output | 7 | Payload byte |
| pay_pin | output | 7 | Data pin of the payload frame |
| pay_type | output | 3 | Effective shift type of the payload frame |
| rd_req | output | 1 | Shift-in request pulse |
| rd_pin | output | 7 | Data pin of the request |
| rd_count | output | 7 | Bytes to shift in |
| rd_type | output | 3 | Effective shift type of the request |
| rp_valid | input | 1 | Reply data byte valid |
| rp_ready | output | 1 | Reply data byte taken |
| rp_data | input | 7 | Reply data byte |
| rp_pin | input | 7 | Data pin of the reply, sampled at its first byte |
| rp_last | input | 1 | Marks the final reply byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Outgoing byte taken |
| tx_data | output | 8 | Outgoing byte |

## Verification
The bench sweeps all eight command codes and all eight shift types, with and without a latch pin. A decoder that read the command or type bits from the wrong field, or that skipped latch suppression, would report the wrong effective type or act on reserved commands. Short config frames and shift-in frames with a missing or zero count check that a design cannot store half a profile or request zero bytes. Aborts in mid-frame, restarts with 0xF0 and foreign feature bytes check that no partial frame leaks into the profile or starts a request. A stalled engine and a stalled output stream check that nothing is dropped or reordered under backpressure.

// File: rtl/shsx_pkg.sv
package shsx_pkg;
  localparam logic [7:0] SOX = 8'hF0;
  localparam logic [7:0] EOX = 8'hF7;
  localparam int FW = 7;
  localparam int NFIELD = 4;
  localparam logic [2:0] NF3 = 3'(NFIELD);

  localparam logic [2:0] CMD_OUT   = 3'd1;
  localparam logic [2:0] CMD_IN    = 3'd2;
  localparam logic [2:0] CMD_REPLY = 3'd3;
  localparam logic [2:0] CMD_CFG   = 3'd4;

  localparam logic [2:0] TY_OUT      = 3'd0;
  localparam logic [2:0] TY_IN       = 3'd1;
  localparam logic [2:0] TY_LL_OUT   = 3'd2;
  localparam logic [2:0] TY_LL_OUT_H = 3'd3;
  localparam logic [2:0] TY_OUT_LH   = 3'd4;
  localparam logic [2:0] TY_LOAD_IN  = 3'd5;

  // Drop latch actions when no latch pin is configured.
  function automatic logic [2:0] eff_type(input logic [2:0] t, input logic lv);
    logic [2:0] r;
    r = t;
    if (!lv) begin
      case (t)
        TY_LL_OUT, TY_LL_OUT_H, TY_OUT_LH: r = TY_OUT;
        TY_LOAD_IN:                        r = TY_IN;
        default:                           r = t;
      endcase
    end
    return r;
  endfunction

  function automatic logic cmd_known(input logic [2:0] c);
    return (c == CMD_OUT) || (c == CMD_IN) || (c == CMD_CFG);
  endfunction

  function automatic logic [FW-1:0] count_or_one(input logic present, input logic [FW-1:0] v);
    return (present && (v != '0)) ? v : FW'(1);
  endfunction
endpackage

// File: rtl/shsx_parser.sv
module shsx_parser
  import shsx_pkg::*;
#(
  parameter logic [7:0] FEATURE_ID = 8'h75
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_ready,
  input  logic          latch_valid,
  output logic          evt_cfg,
  output logic          evt_rd,
  output logic          evt_abort,
  output logic          pay_push,
  output logic [FW-1:0] pay_byte,
  output logic [2:0]    cur_typ,
  output logic [2:0]    cur_nfld,
  output logic [FW-1:0] fld0,
  output logic [FW-1:0] fld1,
  output logic [FW-1:0] fld2,
  output logic [FW-1:0] fld3,
  output logic          rd_req,
  output logic [FW-1:0] rd_pin,
  output logic [FW-1:0] rd_count,
  output logic [2:0]    rd_type
);
  typedef enum logic [2:0] {P_IDLE, P_FEAT, P_CMD, P_FIELD, P_PAY, P_SKIP} pst_e;

  pst_e          st;
  logic [2:0]    cmd_q, typ_q, nfld_q;
  logic [FW-1:0] fld_q [NFIELD];
  logic          acc, is_stat, in_msg, evt_end, fld_wr;

  assign acc      = in_valid && in_ready;
  assign is_stat  = in_data[7];
  assign in_msg   = (st == P_FIELD) || (st == P_PAY);
  assign evt_end  = acc && (in_data == EOX) && in_msg;
  assign evt_cfg  = evt_end && (cmd_q == CMD_CFG) && (nfld_q >= 3'd3);
  assign evt_rd   = evt_end && (cmd_q == CMD_IN) && (nfld_q >= 3'd1);
  assign evt_abort = acc && is_stat && (in_data != EOX) && (st != P_IDLE) && (st != P_SKIP);
  assign pay_push = acc && !is_stat && (st == P_PAY);
  assign pay_byte = in_data[FW-1:0];
  assign fld_wr   = acc && !is_stat && (st == P_FIELD) && (nfld_q < NF3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= P_IDLE;
      cmd_q  <= '0;
      typ_q  <= '0;
      nfld_q <= '0;
    end else if (acc) begin
      if (in_data == SOX) begin
        st     <= P_FEAT;
        nfld_q <= '0;
      end else if (is_stat) begin
        st <= P_IDLE;
      end else begin
        case (st)
          P_FEAT: st <= (in_data == FEATURE_ID) ? P_CMD : P_SKIP;
          P_CMD: begin
            cmd_q <= in_data[2:0];
            typ_q <= in_data[5:3];
            st    <= cmd_known(in_data[2:0]) ? P_FIELD : P_SKIP;
          end
          P_FIELD: begin
            if (nfld_q < NF3) nfld_q <= nfld_q + 3'd1;
            if (cmd_q == CMD_OUT) st <= P_PAY;
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar gi = 0; gi < NFIELD; gi++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              fld_q[gi] <= '0;
      else if (fld_wr && (nfld_q == 3'(gi)))   fld_q[gi] <= in_data[FW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_req   <= 1'b0;
      rd_pin   <= '0;
      rd_count <= '0;
      rd_type  <= '0;
    end else begin
      rd_req <= evt_rd;
      if (evt_rd) begin
        rd_pin   <= fld_q[0];
        rd_count <= count_or_one(nfld_q >= 3'd2, fld_q[1]);
        rd_type  <= eff_type(typ_q, latch_valid);
      end
    end
  end

  assign cur_typ  = typ_q;
  assign cur_nfld = nfld_q;
  assign fld0 = fld_q[0];
  assign fld1 = fld_q[1];
  assign fld2 = fld_q[2];
  assign fld3 = fld_q[3];
endmodule

// File: rtl/shsx_cfg_store.sv
module shsx_cfg_store
  import shsx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_cfg,
  input  logic [2:0]    typ,
  input  logic [2:0]    nfld,
  input  logic [FW-1:0] fld0,
  input  logic [FW-1:0] fld1,
  input  logic [FW-1:0] fld2,
  input  logic [FW-1:0] fld3,
  output logic          cfg_valid,
  output logic [FW-1:0] cfg_data_pin,
  output logic [FW-1:0] cfg_clk_pin,
  output logic          cfg_msb_first,
  output logic [FW-1:0] cfg_latch_pin,
  output logic          cfg_latch_valid,
  output logic [2:0]    cfg_type
);
  logic has_latch;
  assign has_latch = (nfld == NF3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_valid       <= 1'b0;
      cfg_data_pin    <= '0;
      cfg_clk_pin     <= '0;
      cfg_msb_first   <= 1'b0;
      cfg_latch_pin   <= '0;
      cfg_latch_valid <= 1'b0;
      cfg_type        <= '0;
    end else if (evt_cfg) begin
      cfg_valid       <= 1'b1;
      cfg_data_pin    <= fld0;
      cfg_clk_pin     <= fld1;
      cfg_msb_first   <= fld2[0];
      cfg_latch_pin   <= has_latch ? fld3 : '0;
      cfg_latch_valid <= has_latch;
      cfg_type        <= eff_type(typ, has_latch);
    end
  end
endmodule

// File: rtl/shsx_pay_buf.sv
module shsx_pay_buf
  import shsx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [FW-1:0] din,
  input  logic [FW-1:0] pin,
  input  logic [2:0]    typ,
  output logic          can_take,
  output logic          pay_valid,
  input  logic          pay_ready,
  output logic [FW-1:0] pay_data,
  output logic [FW-1:0] pay_pin,
  output logic [2:0]    pay_type
);
  assign can_take = !pay_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_valid <= 1'b0;
      pay_data  <= '0;
      pay_pin   <= '0;
      pay_type  <= '0;
    end else if (push) begin
      pay_valid <= 1'b1;
      pay_data  <= din;
      pay_pin   <= pin;
      pay_type  <= typ;
    end else if (pay_ready) begin
      pay_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/shsx_reply_framer.sv
module shsx_reply_framer
  import shsx_pkg::*;
#(
  parameter logic [7:0] FEATURE_ID = 8'h75
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rp_valid,
  output logic          rp_ready,
  input  logic [FW-1:0] rp_data,
  input  logic [FW-1:0] rp_pin,
  input  logic          rp_last,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data
);
  typedef enum logic [1:0] {F_IDLE, F_HDR, F_DATA, F_END} fst_e;
  localparam logic [7:0] REPLY_BYTE = {5'd0, CMD_REPLY};

  fst_e          st;
  logic [1:0]    hidx;
  logic [FW-1:0] pin_q;

  function automatic logic [7:0] hdr_byte(input logic [1:0] i, input logic [FW-1:0] p);
    case (i)
      2'd0:    return SOX;
      2'd1:    return FEATURE_ID;
      2'd2:    return REPLY_BYTE;
      default: return {1'b0, p};
    endcase
  endfunction

  always_comb begin
    tx_valid = 1'b0;
    tx_data  = '0;
    rp_ready = 1'b0;
    case (st)
      F_HDR: begin
        tx_valid = 1'b1;
        tx_data  = hdr_byte(hidx, pin_q);
      end
      F_DATA: begin
        tx_valid = rp_valid;
        tx_data  = {1'b0, rp_data};
        rp_ready = tx_ready;
      end
      F_END: begin
        tx_valid = 1'b1;
        tx_data  = EOX;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= F_IDLE;
      hidx  <= '0;
      pin_q <= '0;
    end else begin
      case (st)
        F_IDLE: if (rp_valid) begin
          pin_q <= rp_pin;
          hidx  <= '0;
          st    <= F_HDR;
        end
        F_HDR: if (tx_ready) begin
          if (hidx == 2'd3) st <= F_DATA;
          else              hidx <= hidx + 2'd1;
        end
        F_DATA: if (rp_valid && tx_ready && rp_last) st <= F_END;
        F_END:  if (tx_ready) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shift_sysex_decoder.sv
module shift_sysex_decoder
  import shsx_pkg::*;
#(
  parameter logic [7:0] FEATURE_ID = 8'h75
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          cfg_valid,
  output logic [6:0]    cfg_data_pin,
  output logic [6:0]    cfg_clk_pin,
  output logic          cfg_msb_first,
  output logic [6:0]    cfg_latch_pin,
  output logic          cfg_latch_valid,
  output logic [2:0]    cfg_type,
  output logic          pay_valid,
  input  logic          pay_ready,
  output logic [6:0]    pay_data,
  output logic [6:0]    pay_pin,
  output logic [2:0]    pay_type,
  output logic          rd_req,
  output logic [6:0]    rd_pin,
  output logic [6:0]    rd_count,
  output logic [2:0]    rd_type,
  input  logic          rp_valid,
  output logic          rp_ready,
  input  logic [6:0]    rp_data,
  input  logic [6:0]    rp_pin,
  input  logic          rp_last,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data
);
  logic          evt_cfg, evt_rd, evt_abort, pay_push;
  logic [FW-1:0] pay_byte, fld0, fld1, fld2, fld3;
  logic [2:0]    cur_typ, cur_nfld, push_type;

  assign push_type = eff_type(cur_typ, cfg_latch_valid);

  shsx_parser #(.FEATURE_ID(FEATURE_ID)) u_parse (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .latch_valid(cfg_latch_valid),
    .evt_cfg(evt_cfg), .evt_rd(evt_rd), .evt_abort(evt_abort),
    .pay_push(pay_push), .pay_byte(pay_byte), .cur_typ(cur_typ), .cur_nfld(cur_nfld),
    .fld0(fld0), .fld1(fld1), .fld2(fld2), .fld3(fld3),
    .rd_req(rd_req), .rd_pin(rd_pin), .rd_count(rd_count), .rd_type(rd_type)
  );

  shsx_cfg_store u_cfg (
    .clk(clk), .rst_n(rst_n), .evt_cfg(evt_cfg), .typ(cur_typ), .nfld(cur_nfld),
    .fld0(fld0), .fld1(fld1), .fld2(fld2), .fld3(fld3),
    .cfg_valid(cfg_valid), .cfg_data_pin(cfg_data_pin), .cfg_clk_pin(cfg_clk_pin),
    .cfg_msb_first(cfg_msb_first), .cfg_latch_pin(cfg_latch_pin),
    .cfg_latch_valid(cfg_latch_valid), .cfg_type(cfg_type)
  );

  shsx_pay_buf u_buf (
    .clk(clk), .rst_n(rst_n), .push(pay_push), .din(pay_byte), .pin(fld0),
    .typ(push_type), .can_take(in_ready), .pay_valid(pay_valid),
    .pay_ready(pay_ready), .pay_data(pay_data), .pay_pin(pay_pin), .pay_type(pay_type)
  );

  shsx_reply_framer #(.FEATURE_ID(FEATURE_ID)) u_frame (
    .clk(clk), .rst_n(rst_n), .rp_valid(rp_valid), .rp_ready(rp_ready),
    .rp_data(rp_data), .rp_pin(rp_pin), .rp_last(rp_last),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );
endmodule

// File: rtl/shsx_checker.sv
module shsx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pay_valid,
  input logic       pay_ready,
  input logic [6:0] pay_data,
  input logic [6:0] pay_pin,
  input logic [2:0] pay_type,
  input logic       cfg_valid,
  input logic       cfg_latch_valid,
  input logic [6:0] cfg_clk_pin,
  input logic       rd_req,
  input logic [6:0] rd_count,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       evt_cfg,
  input logic       evt_abort
);
  assert_pay_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid && !pay_ready |=> pay_valid && $stable(pay_data) && $stable(pay_pin));

  assert_no_latch_type_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid && !cfg_latch_valid |-> !(pay_type >= 3'd2 && pay_type <= 3'd5));

  assert_cfg_from_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> $past(evt_cfg));

  assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_rd_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_count != 7'd0);

  assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abort |=> !rd_req && $stable(cfg_clk_pin));

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_tx_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_data[7] |-> (tx_data == 8'hF0) || (tx_data == 8'hF7));
endmodule

bind shift_sysex_decoder shsx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pay_valid(pay_valid), .pay_ready(pay_ready),
  .pay_data(pay_data), .pay_pin(pay_pin), .pay_type(pay_type),
  .cfg_valid(cfg_valid), .cfg_latch_valid(cfg_latch_valid), .cfg_clk_pin(cfg_clk_pin),
  .rd_req(rd_req), .rd_count(rd_count), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .evt_cfg(evt_cfg), .evt_abort(evt_abort)
);

// File: tb/sim_shift_sysex_decoder.sv
`timescale 1ns/1ps
module sim_shift_sysex_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, pay_ready = 1'b1, rp_valid = 1'b0, rp_last = 1'b0, tx_ready = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic [6:0] rp_data = '0, rp_pin = '0;
  logic in_ready, cfg_valid, cfg_msb_first, cfg_latch_valid, pay_valid, rd_req, rp_ready, tx_valid;
  logic [6:0] cfg_data_pin, cfg_clk_pin, cfg_latch_pin, pay_data, pay_pin, rd_pin, rd_count;
  logic [2:0] cfg_type, pay_type, rd_type;
  logic [7:0] tx_data;

  int total = 0, bad = 0;
  int n_pay = 0, n_rd = 0, n_tx = 0;
  int pl_d [64], pl_p [64], pl_t [64], tl [64];
  int rd_lp = 0, rd_lc = 0, rd_lt = 0;
  logic stall = 1'b0;

  always #10 clk = ~clk;

  shift_sysex_decoder u0 (.*);

  always @(negedge clk) if (rst_n) begin
    if (pay_valid && pay_ready) begin
      pl_d[n_pay % 64] = pay_data; pl_p[n_pay % 64] = pay_pin; pl_t[n_pay % 64] = pay_type;
      n_pay++;
    end
    if (rd_req) begin rd_lp = rd_pin; rd_lc = rd_count; rd_lt = rd_type; n_rd++; end
    if (tx_valid && tx_ready) begin tl[n_tx % 64] = tx_data; n_tx++; end
  end

  always @(posedge clk) begin
    #2;
    if (stall) tx_ready = ~tx_ready; else tx_ready = 1'b1;
  end

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int exp_type(input int t, input int lv);
    if (lv != 0) return t;
    if (t == 5) return 1;
    if (t >= 2 && t <= 4) return 0;
    return t;
  endfunction

  task automatic send(input int b);
    in_valid = 1'b1; in_data = 8'(b);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2; in_valid = 1'b0;
  endtask

  task automatic settle;
    repeat (3) @(negedge clk);
    @(posedge clk); #2;
  endtask

  task automatic config_msg(input int t, input int dp, input int cp, input int ord, input int lp);
    send(8'hF0); send(8'h75); send((t << 3) | 4);
    send(dp); send(cp); send(ord);
    if (lp >= 0) send(lp);
    send(8'hF7); settle();
  endtask

  task automatic reply(input int pin, input int n, input int seed);
    int base;
    base = n_tx;
    rp_pin = 7'(pin);
    for (int i = 0; i < n; i++) begin
      rp_valid = 1'b1; rp_data = 7'(seed + i); rp_last = (i == n - 1);
      do @(negedge clk); while (!rp_ready);
      @(posedge clk); #2; rp_valid = 1'b0; rp_last = 1'b0;
    end
    repeat (12) @(negedge clk);
    @(posedge clk); #2;
    chk("R9 reply length", n_tx - base, n + 5);
    chk("R9 reply start", tl[base % 64], 8'hF0);
    chk("R9 reply feature", tl[(base + 1) % 64], 8'h75);
    chk("R9 reply command", tl[(base + 2) % 64], 8'h03);
    chk("R9 reply pin", tl[(base + 3) % 64], pin);
    for (int i = 0; i < n; i++) chk("R9 reply data", tl[(base + 4 + i) % 64], seed + i);
    chk("R9 reply end", tl[(base + 4 + n) % 64], 8'hF7);
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int bp, br;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 cfg_valid", cfg_valid, 0);
    chk("R10 latch_valid", cfg_latch_valid, 0);
    chk("R10 pay_valid", pay_valid, 0);
    chk("R10 rd_req", rd_req, 0);
    chk("R10 tx_valid", tx_valid, 0);
    chk("R10 in_ready", in_ready, 1);
    @(posedge clk); #2;

    // R3 / R4: config sweep over types, with and without latch
    for (int lv = 0; lv < 2; lv++) begin
      for (int t = 0; t < 8; t++) begin
        config_msg(t, t + 1, t + 10, t & 1, lv ? t + 20 : -1);
        chk("R3 cfg_valid", cfg_valid, 1);
        chk("R3 data pin", cfg_data_pin, t + 1);
        chk("R3 clock pin", cfg_clk_pin, t + 10);
        chk("R3 bit order", cfg_msb_first, t & 1);
        chk("R3 latch valid", cfg_latch_valid, lv);
        if (lv) chk("R3 latch pin", cfg_latch_pin, t + 20);
        chk("R4 cfg type", cfg_type, exp_type(t, lv));
      end
    end

    // R5 / R4: shift-out sweep
    for (int lv = 0; lv < 2; lv++) begin
      config_msg(0, 3, 4, 1, lv ? 9 : -1);
      for (int t = 0; t < 8; t++) begin
        bp = n_pay;
        send(8'hF0); send(8'h75); send((t << 3) | 1); send(30 + t);
        send(t * 3 + 1); send(t * 3 + 2); send(8'hF7); settle();
        chk("R5 payload count", n_pay - bp, 2);
        chk("R5 first byte", pl_d[bp % 64], t * 3 + 1);
        chk("R5 second byte", pl_d[(bp + 1) % 64], t * 3 + 2);
        chk("R5 payload pin", pl_p[bp % 64], 30 + t);
        chk("R4 payload type", pl_t[bp % 64], exp_type(t, lv));
      end
    end

    // R6: shift-in requests, latch configured
    config_msg(0, 1, 2, 1, 3);
    br = n_rd;
    send(8'hF0); send(8'h75); send((1 << 3) | 2); send(21); send(8'hF7); settle();
    chk("R6 absent count req", n_rd - br, 1);
    chk("R6 absent count", rd_lc, 1);
    chk("R6 pin", rd_lp, 21);
    chk("R6 type", rd_lt, 1);
    send(8'hF0); send(8'h75); send(2); send(22); send(0); send(8'hF7); settle();
    chk("R6 zero count", rd_lc, 1);
    send(8'hF0); send(8'h75); send(2); send(23); send(5); send(8'hF7); settle();
    chk("R6 count five", rd_lc, 5);
    chk("R6 pin 23", rd_lp, 23);
    send(8'hF0); send(8'h75); send((5 << 3) | 2); send(24); send(127); send(99); send(8'hF7); settle();
    chk("R6 count max", rd_lc, 127);
    chk("R6 load type", rd_lt, 5);
    chk("R6 request total", n_rd - br, 4);
    br = n_rd;
    send(8'hF0); send(8'h75); send(2); send(8'hF7); settle();
    chk("R6 no pin no request", n_rd - br, 0);

    // R2: command code sweep
    for (int c = 0; c < 8; c++) begin
      config_msg(0, 50, 50, 0, -1);
      bp = n_pay; br = n_rd;
      send(8'hF0); send(8'h75); send(c); send(11); send(9); send(1); send(8'hF7); settle();
      chk("R2 payloads", n_pay - bp, (c == 1) ? 2 : 0);
      chk("R2 requests", n_rd - br, (c == 2) ? 1 : 0);
      chk("R2 clock pin", cfg_clk_pin, (c == 4) ? 9 : 50);
      if (c == 2) chk("R2 request count", rd_lc, 9);
    end

    // R1: feature identifier and stray bytes
    config_msg(0, 1, 2, 1, -1);
    bp = n_pay;
    send(8'hF0); send(8'h74); send(4); send(1); send(60); send(1); send(8'hF7); settle();
    chk("R1 foreign config ignored", cfg_clk_pin, 2);
    send(8'hF0); send(8'h76); send(1); send(3); send(4); send(8'hF7); settle();
    send(4); send(1); send(2); send(5); send(8'hF7); settle();
    chk("R1 foreign and stray payloads", n_pay - bp, 0);
    send(8'hF0); send(8'h75); send(1); send(5); send(7); send(8'hF7); settle();
    chk("R1 valid after skip", n_pay - bp, 1);
    chk("R1 valid byte", pl_d[bp % 64], 7);

    // R3: short config not stored
    send(8'hF0); send(8'h75); send(4); send(1); send(62); send(8'hF7); settle();
    chk("R3 short config", cfg_clk_pin, 2);

    // R7: aborts and restarts
    send(8'hF0); send(8'h75); send(4); send(1); send(61); send(8'h80); send(3); send(8'hF7); settle();
    chk("R7 aborted config", cfg_clk_pin, 2);
    br = n_rd;
    send(8'hF0); send(8'h75); send(2); send(5); send(8'hF0); send(8'h75); send(2); send(6); send(3); send(8'hF7); settle();
    chk("R7 restart request", n_rd - br, 1);
    chk("R7 restart pin", rd_lp, 6);
    chk("R7 restart count", rd_lc, 3);
    br = n_rd;
    send(8'hF0); send(8'h75); send(2); send(5); send(8'hFE); send(8'hF7); settle();
    chk("R7 aborted request", n_rd - br, 0);
    bp = n_pay;
    send(8'hF0); send(8'h75); send(1); send(8); send(4); send(8'hFE); send(5); send(8'hF7); settle();
    chk("R7 payload stops at abort", n_pay - bp, 1);

    // R8: backpressure from the engine
    bp = n_pay;
    pay_ready = 1'b0;
    send(8'hF0); send(8'h75); send(1); send(7); send(8'h11);
    in_valid = 1'b1; in_data = 8'h22;
    repeat (3) begin
      @(negedge clk);
      chk("R8 in_ready low", in_ready, 0);
      chk("R8 held byte", pay_data, 8'h11);
    end
    @(posedge clk); #2; pay_ready = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2; in_valid = 1'b0;
    send(8'hF7); settle();
    chk("R8 count", n_pay - bp, 2);
    chk("R8 order first", pl_d[bp % 64], 8'h11);
    chk("R8 order second", pl_d[(bp + 1) % 64], 8'h22);

    // R9: reply framing, free-running and stalled
    reply(9, 3, 40);
    stall = 1'b1;
    reply(3, 5, 100);
    stall = 1'b0;
    reply(127, 1, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule